// File: doc/BRIEF.md
# External Bus Mastership Arbitration Controller

This block is the master-side half of the arbitration for a shared external bus. Three active-low wires connect it to the outside: a request it always drives, a grant that an external arbiter returns, and a shared busy line that whichever master owns the bus pulls low. On the inside, the block takes a pending external access, a per-cycle completion strobe from the bus cycle engine, and a software hold bit. From these it decides when this master owns the bus. It reports ownership on a flag and drives the busy line through an enable and a value.

Ownership starts only when two conditions have both been seen: the grant is asserted, and the busy line has gone inactive. From then on the block holds busy low. When accesses stop but the grant remains, the block stays on the bus ("parks"), so later accesses begin without a new arbitration. When the grant goes away, the block finishes the bus cycle in progress. It then drives busy high for exactly one cycle and releases the line, and an external pull-up keeps it high. A run-time mode bit passes grant and busy through a two-flop synchronizer, for systems where these inputs are not timed to the local clock.

Top module: `xbus_master_arb`

## Requirements
- R1: While reset is held and right after it, reqN is 1, ownBus is 0 and busyDrvEn is 0, and the block is in the slave state.
- R2: reqN is a plain register output. One clock after accReq or reqHold is 1 it goes to 0. One clock after both are 0 it returns to 1, whether the block is master or slave at the time.
- R3: reqHold alone asserts reqN. With the grant present and busy idle it also takes the bus, and goes straight into the parked state (ownBus 1, no access running).
- R4: The grant must be asserted, busy must be inactive and the block must want the bus. One clock later ownBus is 1 and busy is driven low (busyDrvEn 1, busyDrvVal 0).
- R5: While the grant is asserted but busy is still active (busyInN 0), ownBus stays 0 and the block does not drive busy.
- R6: The grant may be withdrawn while an access is under way. The block then keeps ownership and busy low until cycDone, even across several clocks.
- R7: Release takes one clock. In it, busyDrvEn is 1, busyDrvVal is 1 and ownBus is 0. On the next clock busyDrvEn is 0.
- R8: cycDone can arrive with the grant still present and no access pending. The block then stays owner with busy driven low (parked).
- R9: A new access while parked takes effect on the next clock. ownBus, busyDrvEn and busyDrvVal keep their values, and no arbitration step comes in between.
- R10: With asyncMode 1, grant and busy each pass through two flops. A grant takes effect two clocks later than with asyncMode 0, so ownership appears on the third clock instead of the first.
- R11: Losing the grant while parked leads to release on the next clock.
- R12: Losing the grant while waiting for busy returns the block to the slave state with no drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| asyncMode | input | 1 | 1: grant and busy go through the two-flop synchronizer |
| accReq | input | 1 | An external access is pending |
| cycDone | input | 1 | The bus cycle engine finishes the current bus cycle in this clock |
| reqHold | input | 1 | Software hold: keep requesting the bus |
| grantN | input | 1 | Bus grant from the external arbiter, active low |
| busyInN | input | 1 | Sampled level of the shared busy line, active low |
| reqN | output | 1 | Bus request, active low, always driven |
| ownBus | output | 1 | This master owns the bus |
| busyDrvEn | output | 1 | Output enable for the busy pad |
| busyDrvVal | output | 1 | Level driven on busy when enabled (0 = busy, 1 = release) |

## Verification
Every output comes from a register that loads at the edge where the conditioned inputs are sampled. In synchronous mode a stimulus is therefore visible one clock later. In asynchronous mode, grant and busy show their effect three clocks later, while reqN still follows after one clock. The bench drives inputs on the falling edge. After each rising edge it advances its own reference model, which includes the two-stage input pipeline for asynchronous mode. It compares the outputs 1 ns after that edge, so every check falls on the exact clock the requirement names.

// File: rtl/xbus_arb_pkg.sv
package xbus_arb_pkg;

  typedef enum logic [2:0] {
    ST_SLAVE     = 3'd0,
    ST_WAIT_BUSY = 3'd1,
    ST_ACTIVE    = 3'd2,
    ST_PARKED    = 3'd3,
    ST_RELEASE   = 3'd4
  } arbState_t;

  // strobes from control to the pad-side datapath, already for the next cycle
  typedef struct packed {
    logic wantBus;
    logic own;
    logic busyDrive;
    logic busyHigh;
  } arbStrobe_t;

endpackage

// File: rtl/xbus_arb_io.sv
module xbus_arb_io
  import xbus_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       asyncMode,
  input  logic       grantN,
  input  logic       busyInN,
  input  arbStrobe_t strobe,
  output logic       gntS,
  output logic       busyS,
  output logic       reqN,
  output logic       ownBus,
  output logic       busyDrvEn,
  output logic       busyDrvVal
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [1:0] rawAct;
  logic [1:0] chain [SYNC_STAGES];
  logic [1:0] condAct;

  assign rawAct = {~busyInN, ~grantN};

  for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 2'b00;
        else       chain[i] <= rawAct;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[i] <= 2'b00;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign condAct = asyncMode ? chain[LAST] : rawAct;
  assign gntS    = condAct[0];
  assign busyS   = condAct[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqN       <= 1'b1;
      ownBus     <= 1'b0;
      busyDrvEn  <= 1'b0;
      busyDrvVal <= 1'b0;
    end else begin
      reqN       <= ~strobe.wantBus;
      ownBus     <= strobe.own;
      busyDrvEn  <= strobe.busyDrive;
      busyDrvVal <= strobe.busyHigh;
    end
  end

  AST_HIGH_DRIVE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (busyDrvEn && busyDrvVal) |=> !(busyDrvEn && busyDrvVal)); // R7

  AST_OWNER_HOLDS_LOW: assert property (@(posedge clk) disable iff (!rstN)
    ownBus |-> (busyDrvEn && !busyDrvVal)); // R4

endmodule

// File: rtl/xbus_arb_ctrl.sv
module xbus_arb_ctrl
  import xbus_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gntS,
  input  logic       busyS,
  input  logic       accReq,
  input  logic       cycDone,
  input  logic       reqHold,
  output arbStrobe_t strobe
);

  arbState_t state, nextState;
  logic      wantBus;
  arbState_t takeState;

  assign wantBus   = accReq | reqHold;
  // on taking the bus, go active if an access waits, otherwise park
  assign takeState = accReq ? ST_ACTIVE : ST_PARKED;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_SLAVE: begin
        if (gntS && wantBus) nextState = busyS ? ST_WAIT_BUSY : takeState;
      end
      ST_WAIT_BUSY: begin
        if (!gntS)       nextState = ST_SLAVE;
        else if (!busyS) nextState = takeState;
      end
      ST_ACTIVE: begin
        if (cycDone) nextState = !gntS ? ST_RELEASE : takeState;
      end
      ST_PARKED: begin
        if (!gntS)       nextState = ST_RELEASE;
        else if (accReq) nextState = ST_ACTIVE;
      end
      ST_RELEASE: nextState = ST_SLAVE;
      default:    nextState = ST_SLAVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SLAVE;
    else       state <= nextState;
  end

  always_comb begin
    strobe.wantBus   = wantBus;
    strobe.own       = (nextState == ST_ACTIVE) || (nextState == ST_PARKED);
    strobe.busyDrive = (nextState == ST_ACTIVE) || (nextState == ST_PARKED) ||
                       (nextState == ST_RELEASE);
    strobe.busyHigh  = (nextState == ST_RELEASE);
  end

  AST_OWN_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (((state == ST_ACTIVE) || (state == ST_PARKED)) &&
     (($past(state) == ST_SLAVE) || ($past(state) == ST_WAIT_BUSY)))
    |-> ($past(gntS) && !$past(busyS))); // R4

  AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASE) |=> (state == ST_SLAVE)); // R7

  AST_PARK_LOSS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PARKED) && !gntS) |=> (state == ST_RELEASE)); // R11

  AST_NO_MIDCYCLE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_ACTIVE) && !cycDone) |=> (state == ST_ACTIVE)); // R6

  AST_WAIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_WAIT_BUSY) && gntS && busyS) |=> (state == ST_WAIT_BUSY)); // R5

endmodule

// File: rtl/xbus_master_arb.sv
module xbus_master_arb
  import xbus_arb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncMode,
  input  logic accReq,
  input  logic cycDone,
  input  logic reqHold,
  input  logic grantN,
  input  logic busyInN,
  output logic reqN,
  output logic ownBus,
  output logic busyDrvEn,
  output logic busyDrvVal
);

  arbStrobe_t strobe;
  logic       gntS;
  logic       busyS;

  xbus_arb_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .gntS    (gntS),
    .busyS   (busyS),
    .accReq  (accReq),
    .cycDone (cycDone),
    .reqHold (reqHold),
    .strobe  (strobe)
  );

  xbus_arb_io #(.SYNC_STAGES(SYNC_STAGES)) u_io (
    .clk        (clk),
    .rstN       (rstN),
    .asyncMode  (asyncMode),
    .grantN     (grantN),
    .busyInN    (busyInN),
    .strobe     (strobe),
    .gntS       (gntS),
    .busyS      (busyS),
    .reqN       (reqN),
    .ownBus     (ownBus),
    .busyDrvEn  (busyDrvEn),
    .busyDrvVal (busyDrvVal)
  );

endmodule

// File: tb/xbus_master_arb_tb.sv
`timescale 1ns/1ps
module xbus_master_arb_tb;

  logic clk = 1'b0;
  logic rstN, asyncMode, accReq, cycDone, reqHold, grantN, busyInN;
  logic reqN, ownBus, busyDrvEn, busyDrvVal;

  int testCnt = 0;
  int failCnt = 0;

  // reference model state: 0 slave,1 wait,2 active,3 parked,4 release
  int   mSt;
  logic mReqN;
  logic [1:0] mg, mb;

  always #2.5 clk = ~clk;

  xbus_master_arb u_dut (
    .clk(clk), .rstN(rstN), .asyncMode(asyncMode), .accReq(accReq),
    .cycDone(cycDone), .reqHold(reqHold), .grantN(grantN), .busyInN(busyInN),
    .reqN(reqN), .ownBus(ownBus), .busyDrvEn(busyDrvEn), .busyDrvVal(busyDrvVal)
  );

  function automatic int nextModel(int st, logic g, logic b, logic a, logic c, logic h);
    int take = a ? 2 : 3;
    case (st)
      0: return (g && (a || h)) ? (b ? 1 : take) : 0;
      1: return !g ? 0 : (!b ? take : 1);
      2: return c ? (!g ? 4 : take) : 2;
      3: return !g ? 4 : (a ? 2 : 3);
      default: return 0;
    endcase
  endfunction

  task automatic modelStep();
    logic g = asyncMode ? mg[1] : ~grantN;
    logic b = asyncMode ? mb[1] : ~busyInN;
    mSt   = nextModel(mSt, g, b, accReq, cycDone, reqHold);
    mReqN = ~(accReq | reqHold);
    mg    = {mg[0], ~grantN};
    mb    = {mb[0], ~busyInN};
  endtask

  task automatic compare(string tag);
    logic [3:0] exp, act;
    exp = {mReqN, (mSt == 2 || mSt == 3), (mSt >= 2), (mSt == 4)};
    act = {reqN, ownBus, busyDrvEn, busyDrvVal};
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: {reqN,own,en,val} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkBit(string tag, logic actual, logic expected);
    testCnt++;
    if (actual !== expected) begin
      failCnt++;
      $display("FAIL %s: actual %b expected %b", tag, actual, expected);
    end
  endtask

  // a/c/h plain, g/b as "asserted" flags
  task automatic step(logic a, logic c, logic h, logic g, logic b, string tag);
    accReq = a; cycDone = c; reqHold = h; grantN = ~g; busyInN = ~b;
    @(posedge clk);
    modelStep();
    #1;
    compare(tag);
    @(negedge clk);
  endtask

  task automatic doReset(logic mode);
    asyncMode = mode; rstN = 1'b0;
    accReq = 0; cycDone = 0; reqHold = 0; grantN = 1; busyInN = 1;
    mSt = 0; mReqN = 1; mg = 0; mb = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 200000);
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    doReset(1'b0);
    step(0, 0, 0, 0, 0, "R1 idle after reset");
    checkBit("R1 own after reset", ownBus, 1'b0);

    // R2 request, R5 wait for busy, R4 take
    step(1, 0, 0, 0, 1, "R2 request asserted");
    checkBit("R2 reqN low", reqN, 1'b0);
    step(1, 0, 0, 1, 1, "R5 granted but busy");
    step(1, 0, 0, 1, 1, "R5 still busy");
    checkBit("R5 no drive", busyDrvEn, 1'b0);
    step(1, 0, 0, 1, 0, "R4 take bus");
    checkBit("R4 own", ownBus, 1'b1);
    // R6 grant lost mid access
    step(1, 0, 0, 0, 1, "R6 hold until done");
    step(0, 0, 0, 0, 1, "R6 hold until done 2");
    checkBit("R6 still owner", ownBus, 1'b1);
    checkBit("R2 reqN high while master", reqN, 1'b1);
    step(0, 1, 0, 0, 1, "R7 enter release");
    checkBit("R7 drive high", busyDrvVal, 1'b1);
    step(0, 0, 0, 0, 0, "R7 tristate after release");
    checkBit("R7 released", busyDrvEn, 1'b0);

    // R3 hold bit parks
    step(0, 0, 1, 1, 0, "R3 hold takes bus parked");
    checkBit("R3 own", ownBus, 1'b1);
    step(1, 0, 0, 1, 1, "R9 access from park");
    step(1, 0, 0, 1, 1, "R9 active");
    step(0, 1, 0, 1, 1, "R8 park after done");
    checkBit("R8 still owner", ownBus, 1'b1);
    step(0, 0, 0, 0, 0, "R11 release on grant loss");
    checkBit("R11 drive high", busyDrvVal, 1'b1);
    step(0, 0, 0, 0, 0, "R11 back to slave");

    // R12 grant lost while waiting
    step(1, 0, 0, 1, 1, "R12 wait");
    step(1, 0, 0, 0, 1, "R12 back to slave");
    checkBit("R12 no drive", busyDrvEn, 1'b0);
    step(0, 0, 0, 0, 0, "R12 idle");

    // R10 asynchronous mode latency
    doReset(1'b1);
    step(1, 0, 0, 1, 0, "R10 sync stage 1");
    checkBit("R10 not yet 1", ownBus, 1'b0);
    step(1, 0, 0, 1, 0, "R10 sync stage 2");
    checkBit("R10 not yet 2", ownBus, 1'b0);
    step(1, 0, 0, 1, 0, "R10 owner");
    checkBit("R10 owner", ownBus, 1'b1);

    // random phases in both modes
    for (int mode = 0; mode < 2; mode++) begin
      logic a = 0, h = 0, g = 0, b = 0;
      doReset(mode[0]);
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(7) == 0)  g = ~g;
        if ($urandom_range(3) == 0)  b = ~b;
        if ($urandom_range(5) == 0)  a = ~a;
        if ($urandom_range(19) == 0) h = ~h;
        step(a, ($urandom_range(2) == 0), h, g, b, "R9 random model compare");
      end
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule